// File: doc/BRIEF.md
# Hardware Monitor Control and Interrupt Registers

This block is the register core that sits between a hardware monitor's measurement scanner and its host. A plain byte-wide register port gives access to one configuration register, two interrupt status registers and two interrupt mask registers. Fault event lines from the limit comparators of the voltage, temperature, fan and chassis channels are gathered into sticky status bits while monitoring runs. The block drives an active-low interrupt line from those status bits, after applying the masks.

The configuration register starts and pauses the scanner through `mon_en` and gates the interrupt line. It also carries three self-clearing command bits. Two of them launch timed active-low pulses, one on a reset output and one on a chassis-intrusion output. The third reloads every register to its power-on value. Status registers clear when they are read. A fault that is still present at the time of the read sets its bit again at once. A separate hold bit releases the interrupt line and pauses monitoring, and it leaves the status contents untouched.

Top module: `hwmon_ctrl_regs`

## Requirements
- R1: After reset the configuration register (40h) reads 08h. Status 1 (41h), status 2 (42h), mask 1 (43h) and mask 2 (44h) read 00h. `irq_n`, `rst_out_n` and `ci_out_n` are 1 and `mon_en` is 0. Any unmapped address reads 00h.
- R2: Configuration bits 0 (run), 1 (interrupt enable) and 3 (interrupt hold) can be written and read back. Bits 2, 4, 5, 6 and 7 always read 0.
- R3: `mon_en` is 1 exactly when run is 1 and hold is 0. While `mon_en` is 0 the status registers latch no events.
- R4: While `mon_en` is 1, a 1 on `ev1[i]` sets bit i of status 1 for i = 0..7 except bit 5, which stays 0. A 1 on `ev2[i]` sets bit i of status 2 for i = 0, 1, 4, and all other bits of status 2 stay 0. The bits are sticky.
- R5: A read of 41h or 42h returns the current contents. The register then takes the events present in the read cycle (if `mon_en` is 1), or 00h otherwise. Writes to 41h and 42h are ignored.
- R6: `irq_n` is 0 exactly when interrupt enable is 1, hold is 0, and some status bit is 1 while the mask bit at the same position (mask 1 for status 1, mask 2 for status 2) is 0.
- R7: Setting hold drives `irq_n` to 1 and leaves the status registers unchanged. Clearing run while `irq_n` is 0 leaves `irq_n` at 0.
- R8: Writing 40h with bit 7 = 0 and bit 4 = 1 drives `rst_out_n` low for exactly PULSE_CYC cycles, starting with the cycle after the write. A new such write restarts the count.
- R9: Writing 40h with bit 7 = 0 and bit 6 = 1 does the same on `ci_out_n`, with its own counter.
- R10: Writing 40h with bit 7 = 1 reloads configuration to 08h and all status and mask registers to 00h. All other bits of that write are ignored, and pulses already in progress continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears status on read) |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| ev1 | input | 8 | Fault events for status 1 |
| ev2 | input | 8 | Fault events for status 2 |
| mon_en | output | 1 | Monitoring enable to the scanner |
| irq_n | output | 1 | Active-low interrupt |
| rst_out_n | output | 1 | Active-low timed reset pulse |
| ci_out_n | output | 1 | Active-low timed chassis-intrusion pulse |

## Verification
The bench reads a status register while its fault is still present. A design that cleared the bit without re-latching the fault would lose that interrupt, and the bench would see it missing. The bench sets hold with faults pending. An implementation that cleared status to drop the line would show empty status on the next read, and one that kept latching would show new bits. The bench retriggers a pulse in the middle of its count and overlaps it with a register reload. A counter that ignored the restart, or was cleared by the reload, would end the pulse too early. Reserved status positions and standby latching run under random event traffic, so a wrong valid mask or a missing gate shows up as a read mismatch.

// File: rtl/hwmon_ctrl_regs.sv
module hwmon_ctrl_regs #(
  parameter int unsigned PULSE_CYC = 2500000,
  parameter logic [7:0]  A_CFG  = 8'h40,
  parameter logic [7:0]  A_ST1  = 8'h41,
  parameter logic [7:0]  A_ST2  = 8'h42,
  parameter logic [7:0]  A_MSK1 = 8'h43,
  parameter logic [7:0]  A_MSK2 = 8'h44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] ev1,
  input  logic [7:0] ev2,
  output logic       mon_en,
  output logic       irq_n,
  output logic       rst_out_n,
  output logic       ci_out_n
);
  localparam int CW = $clog2(PULSE_CYC + 1);
  localparam logic [7:0] CFG_DEF   = 8'h08;
  localparam logic [7:0] CFG_RW    = 8'h0B;
  localparam logic [7:0] ST1_VALID = 8'hDF;
  localparam logic [7:0] ST2_VALID = 8'h13;

  logic [7:0]    cfg_q, sts1_q, sts2_q, msk1_q, msk2_q;
  logic [CW-1:0] rcnt_q, ccnt_q;
  logic          cfg_wr, init, cfg_ld, rd1, rd2;
  logic [7:0]    hit1, hit2;

  assign cfg_wr = wr_en && (addr == A_CFG);
  assign init   = cfg_wr && wdata[7];
  assign cfg_ld = cfg_wr && !wdata[7];
  assign rd1    = rd_en && (addr == A_ST1);
  assign rd2    = rd_en && (addr == A_ST2);

  assign mon_en = cfg_q[0] & ~cfg_q[3];
  assign hit1   = mon_en ? (ev1 & ST1_VALID) : 8'h00;
  assign hit2   = mon_en ? (ev2 & ST2_VALID) : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_DEF;
      sts1_q <= 8'h00;
      sts2_q <= 8'h00;
      msk1_q <= 8'h00;
      msk2_q <= 8'h00;
    end else if (init) begin
      cfg_q  <= CFG_DEF;
      sts1_q <= 8'h00;
      sts2_q <= 8'h00;
      msk1_q <= 8'h00;
      msk2_q <= 8'h00;
    end else begin
      if (cfg_ld) cfg_q <= wdata & CFG_RW;
      sts1_q <= (rd1 ? 8'h00 : sts1_q) | hit1;
      sts2_q <= (rd2 ? 8'h00 : sts2_q) | hit2;
      if (wr_en && addr == A_MSK1) msk1_q <= wdata;
      if (wr_en && addr == A_MSK2) msk2_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      ccnt_q <= '0;
    end else begin
      if (cfg_ld && wdata[4])  rcnt_q <= CW'(PULSE_CYC);
      else if (rcnt_q != '0)   rcnt_q <= rcnt_q - CW'(1);
      if (cfg_ld && wdata[6])  ccnt_q <= CW'(PULSE_CYC);
      else if (ccnt_q != '0)   ccnt_q <= ccnt_q - CW'(1);
    end
  end

  assign rst_out_n = (rcnt_q == '0);
  assign ci_out_n  = (ccnt_q == '0);
  assign irq_n = ~(cfg_q[1] & ~cfg_q[3] &
                   (|((sts1_q & ~msk1_q) | (sts2_q & ~msk2_q))));

  always_comb begin
    case (addr)
      A_CFG:   rdata = cfg_q;
      A_ST1:   rdata = sts1_q;
      A_ST2:   rdata = sts2_q;
      A_MSK1:  rdata = msk1_q;
      A_MSK2:  rdata = msk2_q;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/hwmon_ctrl_regs_chk.sv
module hwmon_ctrl_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic       mon_en,
  input logic       irq_n,
  input logic       rst_out_n,
  input logic       ci_out_n,
  input logic [7:0] cfg_q,
  input logic [7:0] sts1_q
);
  logic cfg_cmd;
  assign cfg_cmd = wr_en && addr == 8'h40;

  AST_HOLD_RELEASES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cmd && !wdata[7] && wdata[3] |=> irq_n); // R7
  AST_RST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cmd && !wdata[7] && wdata[4] |=> !rst_out_n); // R8
  AST_RST_PULSE_NOT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_out_n) |=> !rst_out_n); // R8
  AST_CI_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cmd && !wdata[7] && wdata[6] |=> !ci_out_n); // R9
  AST_INIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cmd && wdata[7] |=> cfg_q == 8'h08 && sts1_q == 8'h00); // R10
  AST_STANDBY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_en && !(rd_en && addr == 8'h41) && !(cfg_cmd && wdata[7])
    |=> sts1_q == $past(sts1_q)); // R3
endmodule

bind hwmon_ctrl_regs hwmon_ctrl_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .mon_en(mon_en), .irq_n(irq_n), .rst_out_n(rst_out_n),
  .ci_out_n(ci_out_n), .cfg_q(cfg_q), .sts1_q(sts1_q)
);

// File: tb/hwmon_ctrl_regs_tb_top.sv
module hwmon_ctrl_regs_tb_top;
  localparam int P = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, wr_en, rd_en;
  logic [7:0] addr, wdata, rdata, ev1, ev2;
  logic       mon_en, irq_n, rst_out_n, ci_out_n;

  hwmon_ctrl_regs #(.PULSE_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ev1(ev1), .ev2(ev2), .mon_en(mon_en),
    .irq_n(irq_n), .rst_out_n(rst_out_n), .ci_out_n(ci_out_n));

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_cfg, m_s1, m_s2, m_k1, m_k2;
  int m_rc, m_cc;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] rd_m(input logic [7:0] a);
    case (a)
      8'h40: return m_cfg;
      8'h41: return m_s1;
      8'h42: return m_s2;
      8'h43: return m_k1;
      8'h44: return m_k2;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq_n();
    return ~(m_cfg[1] & ~m_cfg[3] & (|((m_s1 & ~m_k1) | (m_s2 & ~m_k2))));
  endfunction

  task automatic model_reset();
    m_cfg = 8'h08; m_s1 = 0; m_s2 = 0; m_k1 = 0; m_k2 = 0;
  endtask

  task automatic model_step(input logic we, input logic re, input logic [7:0] a, input logic [7:0] d);
    logic mon;
    mon = m_cfg[0] & ~m_cfg[3];
    m_rc = (m_rc > 0) ? m_rc - 1 : 0;
    m_cc = (m_cc > 0) ? m_cc - 1 : 0;
    if (we && a == 8'h40 && d[7]) begin
      model_reset();
    end else begin
      if (we && a == 8'h40) begin
        m_cfg = d & 8'h0B;
        if (d[4]) m_rc = P;
        if (d[6]) m_cc = P;
      end
      m_s1 = ((re && a == 8'h41) ? 8'h00 : m_s1) | (mon ? (ev1 & 8'hDF) : 8'h00);
      m_s2 = ((re && a == 8'h42) ? 8'h00 : m_s2) | (mon ? (ev2 & 8'h13) : 8'h00);
      if (we && a == 8'h43) m_k1 = d;
      if (we && a == 8'h44) m_k2 = d;
    end
  endtask

  task automatic outs();
    chk("R6", {7'b0, irq_n}, {7'b0, exp_irq_n()});
    chk("R3", {7'b0, mon_en}, {7'b0, m_cfg[0] & ~m_cfg[3]});
    chk("R8", {7'b0, rst_out_n}, {7'b0, m_rc == 0});
    chk("R9", {7'b0, ci_out_n}, {7'b0, m_cc == 0});
  endtask

  task automatic cyc(input logic we, input logic re, input logic [7:0] a,
                     input logic [7:0] d, input string tag);
    wr_en = we; rd_en = re; addr = a; wdata = d;
    #1;
    if (re) chk(tag, rdata, rd_m(a));
    model_step(we, re, a, d);
    @(posedge clk); @(negedge clk);
    wr_en = 0; rd_en = 0;
    outs();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, 8'h00, "");
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b0, a, d, "");
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 8'h00, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; ev1 = 0; ev2 = 0;
    model_reset(); m_rc = 0; m_cc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", {irq_n, rst_out_n, ci_out_n, mon_en}, 4'b1110);
    rd(8'h40, "R1"); rd(8'h41, "R1"); rd(8'h42, "R1");
    rd(8'h43, "R1"); rd(8'h44, "R1"); rd(8'h7F, "R1");
    // R3 standby: no latching
    ev1 = 8'hFF; ev2 = 8'hFF; idle(2);
    rd(8'h41, "R3");
    // R4 latching with reserved bits
    wr(8'h40, 8'h03); idle(1);
    ev1 = 8'h00; ev2 = 8'h00; idle(1);
    rd(8'h41, "R4"); rd(8'h42, "R4");
    // R5 clear on read, and re-set when fault persists
    rd(8'h41, "R5");
    ev1 = 8'h04; idle(1);
    rd(8'h41, "R5"); rd(8'h41, "R5"); ev1 = 0; rd(8'h41, "R5"); rd(8'h41, "R5");
    wr(8'h41, 8'hFF); rd(8'h41, "R5");
    // R6 masking
    wr(8'h43, 8'hFF); wr(8'h44, 8'hFF);
    ev1 = 8'h40; ev2 = 8'h10; idle(1); ev1 = 0; ev2 = 0; idle(1);
    wr(8'h44, 8'hEF); idle(1); wr(8'h43, 8'h00); idle(1);
    // R7 hold releases the line, status untouched; stopping keeps it low
    wr(8'h40, 8'h0B); rd(8'h41, "R7"); rd(8'h42, "R7");
    ev1 = 8'h01; idle(1); ev1 = 0;
    wr(8'h40, 8'h03); idle(1); wr(8'h40, 8'h02); idle(2);
    // R8 / R9 pulses with restart
    wr(8'h40, 8'h12); idle(3); wr(8'h40, 8'h12); idle(P + 2);
    wr(8'h40, 8'h42); idle(2); wr(8'h40, 8'h50); idle(P + 2);
    // R10 reload during a pulse
    wr(8'h43, 8'h5A); wr(8'h40, 8'h13); idle(1);
    wr(8'h40, 8'hDB);
    rd(8'h40, "R10"); rd(8'h43, "R10"); rd(8'h41, "R10"); idle(P);
    // R2 reserved and self-clearing bits read 0
    wr(8'h40, 8'h7F); rd(8'h40, "R2"); idle(P + 1);
    wr(8'h40, 8'h24); rd(8'h40, "R2");
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [7:0] d;
      r = $urandom % 16;
      d = 8'($urandom);
      if (r < 3) begin
        if ($urandom % 8 != 0) d[7] = 1'b0;
        if ($urandom % 2 == 0) d[3] = 1'b0;
        wr(8'h40, d);
      end else if (r < 5) wr(8'h43 + 8'(r - 3), d);
      else if (r < 8) rd(8'h41 + 8'($urandom % 2), "R5");
      else if (r == 8) rd(8'h40 + 8'($urandom % 5), "R2");
      else if (r < 11) begin
        ev1 = 8'($urandom) & 8'($urandom) & 8'($urandom);
        ev2 = 8'($urandom) & 8'($urandom);
        idle(1);
      end else idle(1);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule